// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block turns one 32-bit block-transfer instruction into a stream of micro-operations. The instruction names a base register and carries a 16-bit register list. The stream starts with a copy of the base register. It then gives one single-register load or store per listed register, each at its own byte offset from the base. When the instruction asks for it, the stream ends with an encoded base-register update. A five-bit addressing-mode field picks where the first offset starts and which way the offsets move.

The instruction comes in on a valid/ready port. Micro-ops leave one per cycle on a second valid/ready port, and the final one carries a last flag. A mode code outside the supported set is still accepted. It produces no micro-ops and raises a one-cycle error pulse instead. Memory access, the register file and condition evaluation are handled by the surrounding pipeline.

Top module: `ldm_uop_seq`

## Requirements
- R1: `in_ready` is high exactly when no sequence is in progress. An instruction is taken on a cycle where `in_valid` and `in_ready` are both high, and its first micro-op is valid on the following cycle. While a sequence is in progress, `in_valid` has no effect.
- R2: The instruction fields are as follows. Bits [31:28] hold the condition. Bits [24:20] hold the mode, with P at bit 24, U at 23, S at 22, W at 21 and L at 20. Bits [19:16] hold the base register and bits [15:0] the register list. A sequence has popcount(list) + 1 + W micro-ops.
- R3: The first micro-op has kind 0 (base copy). It carries the base register as its register index, offset 0, load flag 0, and a word equal to the instruction with its low 16 bits cleared.
- R4: Each transfer micro-op has kind 1. Transfers come in ascending register index, and each carries its register index, the L bit as its load flag, and a word of 0.
- R5: Let n be the popcount of the list. The first transfer offset depends on P and U. P=0,U=0 starts at 4n-4. P=0,U=1 starts at 0. P=1,U=0 starts at 4n. P=1,U=1 starts at 4.
- R6: Each later transfer offset is the previous one plus 4 when U=1, and minus 4 when U=0.
- R7: The mode codes 0x01, 0x03, 0x08, 0x09, 0x0B, 0x11, 0x12, 0x18 and 0x19 are supported. Any other code is still accepted. On the cycle after acceptance it raises `bad_mode` for one cycle and emits no micro-op.
- R8: When W=1 the last micro-op is the writeback. Its register index is the base and its offset is 0. Its word is built from three parts: the condition bits [31:28]; 0x02400000; and the base number in bits [19:16] and again in bits [15:12], with 4n in bits [11:0].
- R9: The writeback kind is 2 (add) when U=1 and 3 (subtract) when U=0.
- R10: `out_last` is high on the final micro-op of a sequence and on no other. An empty list gives only the base copy, plus the writeback when W=1.
- R11: While `out_valid` is high and `out_ready` is low, every output field holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Sequencer idle, can take an instruction |
| in_instr | input | 32 | Block-transfer instruction |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | 0 base copy, 1 transfer, 2 writeback add, 3 writeback subtract |
| out_reg | output | 4 | Register index |
| out_offset | output | 8 | Signed byte offset from the base |
| out_load | output | 1 | 1 load, 0 store (transfers only) |
| out_word | output | 32 | Encoded word for base copy and writeback |
| out_last | output | 1 | Final micro-op of the sequence |
| bad_mode | output | 1 | One-cycle pulse for an unsupported mode |

## Verification
The embedded properties watch these rules on every cycle:
- outputs stay stable under back-pressure;
- no new instruction is taken while busy;
- a rejected mode shows no micro-op;
- consecutive transfer offsets differ by exactly 4 in the U direction;
- the writeback is always last;
- nothing is valid right after a consumed last.

Some behaviour only the bench scenarios can show. This covers the exact start offset for each mode, the ascending register order, the full writeback word, the operation count per instruction, and the empty-list and full-list corners. The bench checks all of these against a model of its own, written from the requirements.

// File: rtl/ldm_uop_pkg.sv
package ldm_uop_pkg;

  typedef enum logic [1:0] {
    UK_BASE   = 2'd0,
    UK_XFER   = 2'd1,
    UK_WB_ADD = 2'd2,
    UK_WB_SUB = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BASE = 2'd1,
    SQ_XFER = 2'd2,
    SQ_WB   = 2'd3
  } seq_state_e;

  // Base copy: upper half of the instruction only.
  function automatic logic [31:0] base_copy_word(input logic [31:0] ins);
    return {ins[31:16], 16'h0000};
  endfunction

  // Base update: condition, fixed opcode bits, base as source and
  // destination, byte span as immediate.
  function automatic logic [31:0] wb_word(input logic [31:0] ins,
                                          input logic [11:0] span);
    logic [31:0] w;
    w = {ins[31:28], 28'h0} | 32'h0240_0000;
    w[19:16] = ins[19:16];
    w[15:12] = ins[19:16];
    w[11:0]  = span;
    return w;
  endfunction

endpackage

// File: rtl/ldm_mode_dec.sv
module ldm_mode_dec #(
  parameter int LIST_W = 16,
  parameter int OFF_W  = 8,
  localparam int CNT_W = $clog2(LIST_W + 1)
) (
  input  logic [4:0]        mode,
  input  logic [LIST_W-1:0] list,
  output logic              mode_ok,
  output logic [CNT_W-1:0]  n_regs,
  output logic [OFF_W-1:0]  start_off
);

  always_comb begin
    n_regs = '0;
    for (int i = 0; i < LIST_W; i++) n_regs = n_regs + CNT_W'(list[i]);
  end

  always_comb begin
    unique case (mode)
      5'h01, 5'h03, 5'h08, 5'h09, 5'h0B,
      5'h11, 5'h12, 5'h18, 5'h19: mode_ok = 1'b1;
      default:                    mode_ok = 1'b0;
    endcase
  end

  // mode[4] = pre-index, mode[3] = ascending
  always_comb begin
    unique case (mode[4:3])
      2'b00:   start_off = OFF_W'(4 * int'(n_regs) - 4);
      2'b01:   start_off = '0;
      2'b10:   start_off = OFF_W'(4 * int'(n_regs));
      default: start_off = OFF_W'(4);
    endcase
  end

endmodule

// File: rtl/ldm_low_pick.sv
module ldm_low_pick #(
  parameter int LIST_W = 16,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] mask,
  output logic              any,
  output logic [IDX_W-1:0]  idx,
  output logic [LIST_W-1:0] rest
);

  logic [LIST_W-1:0] below;   // bit i set when some lower bit is set

  genvar g;
  generate
    for (g = 0; g < LIST_W; g++) begin : g_below
      if (g == 0) begin : g_first
        assign below[g] = 1'b0;
      end else begin : g_next
        assign below[g] = below[g-1] | mask[g-1];
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = LIST_W - 1; i >= 0; i--)
      if (mask[i]) idx = IDX_W'(i);
  end

  assign any  = |mask;
  assign rest = mask & below;

endmodule

// File: rtl/ldm_uop_seq.sv
module ldm_uop_seq #(
  parameter int LIST_W = 16,
  parameter int OFF_W  = 8,
  localparam int CNT_W = $clog2(LIST_W + 1),
  localparam int IDX_W = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [IDX_W-1:0]  out_reg,
  output logic [OFF_W-1:0]  out_offset,
  output logic              out_load,
  output logic [31:0]       out_word,
  output logic              out_last,
  output logic              bad_mode
);
  import ldm_uop_pkg::*;

  seq_state_e        st_q;
  logic [31:0]       ins_q;
  logic [LIST_W-1:0] mask_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  n_q;
  logic              bad_q;

  logic              dec_ok;
  logic [CNT_W-1:0]  dec_n;
  logic [OFF_W-1:0]  dec_start;
  logic              pk_any;
  logic [IDX_W-1:0]  pk_idx;
  logic [LIST_W-1:0] pk_rest;

  // named events
  logic in_fire, out_fire, xfer_fire, reject_fire;
  logic up_q, wb_q;

  ldm_mode_dec #(.LIST_W(LIST_W), .OFF_W(OFF_W)) u_dec (
    .mode      (in_instr[24:20]),
    .list      (in_instr[LIST_W-1:0]),
    .mode_ok   (dec_ok),
    .n_regs    (dec_n),
    .start_off (dec_start)
  );

  ldm_low_pick #(.LIST_W(LIST_W)) u_pick (
    .mask (mask_q),
    .any  (pk_any),
    .idx  (pk_idx),
    .rest (pk_rest)
  );

  assign up_q        = ins_q[23];
  assign wb_q        = ins_q[21];
  assign in_ready    = (st_q == SQ_IDLE);
  assign in_fire     = in_valid && in_ready;
  assign reject_fire = in_fire && !dec_ok;
  assign out_valid   = (st_q != SQ_IDLE);
  assign out_fire    = out_valid && out_ready;
  assign xfer_fire   = out_fire && (st_q == SQ_XFER);
  assign bad_mode    = bad_q;

  always_comb begin
    out_kind   = UK_BASE;
    out_reg    = IDX_W'(ins_q[19:16]);
    out_offset = '0;
    out_load   = 1'b0;
    out_word   = '0;
    out_last   = 1'b0;
    unique case (st_q)
      SQ_BASE: begin
        out_kind = UK_BASE;
        out_word = base_copy_word(ins_q);
        out_last = !pk_any && !wb_q;
      end
      SQ_XFER: begin
        out_kind   = UK_XFER;
        out_reg    = pk_idx;
        out_offset = off_q;
        out_load   = ins_q[20];
        out_last   = (pk_rest == '0) && !wb_q;
      end
      SQ_WB: begin
        out_kind = up_q ? UK_WB_ADD : UK_WB_SUB;
        out_word = wb_word(ins_q, 12'(4 * int'(n_q)));
        out_last = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ins_q  <= '0;
      mask_q <= '0;
      off_q  <= '0;
      n_q    <= '0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= reject_fire;
      unique case (st_q)
        SQ_IDLE: if (in_fire && dec_ok) begin
          ins_q  <= in_instr;
          mask_q <= in_instr[LIST_W-1:0];
          off_q  <= dec_start;
          n_q    <= dec_n;
          st_q   <= SQ_BASE;
        end
        SQ_BASE: if (out_fire) begin
          if (pk_any)    st_q <= SQ_XFER;
          else if (wb_q) st_q <= SQ_WB;
          else           st_q <= SQ_IDLE;
        end
        SQ_XFER: if (out_fire) begin
          mask_q <= pk_rest;
          off_q  <= up_q ? off_q + OFF_W'(4) : off_q - OFF_W'(4);
          if (pk_rest == '0) st_q <= wb_q ? SQ_WB : SQ_IDLE;
        end
        SQ_WB: if (out_fire) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);                                              // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_reg) && $stable(out_offset) && $stable(out_word) &&
      $stable(out_last) && $stable(out_load)));                            // R11
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> !out_valid);                                              // R7
  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && pk_rest != '0) |=> (out_kind == UK_XFER &&
      out_offset == ($past(up_q) ? $past(out_offset) + OFF_W'(4)
                                 : $past(out_offset) - OFF_W'(4))));       // R6
  AST_WB_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind[1]) |-> out_last);                              // R8
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> !out_valid);                                // R10

endmodule

// File: tb/ldm_uop_seq_bench.sv
module ldm_uop_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_kind;
  logic [3:0]  out_reg;
  logic [7:0]  out_offset;
  logic        out_load;
  logic [31:0] out_word;
  logic        out_last;
  logic        bad_mode;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ldm_uop_seq u_ldm_uop_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_reg(out_reg), .out_offset(out_offset),
    .out_load(out_load), .out_word(out_word), .out_last(out_last),
    .bad_mode(bad_mode)
  );

  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    32'hE8BD8FF0, 32'hE92D4010, 32'h08910003, 32'h48130081, 32'hE8330005,
    32'h18840001, 32'hE9150006, 32'hE986FFFF, 32'hE9970000, 32'hE8B20000
  };
  localparam int VCNT [NV] = '{11, 4, 3, 3, 4, 2, 3, 17, 1, 2};

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int b_start(input logic [31:0] ins, input int n);
    case ({ins[24], ins[23]})
      2'b00:   return 4 * n - 4;
      2'b01:   return 0;
      2'b10:   return 4 * n;
      default: return 4;
    endcase
  endfunction

  // Accept one instruction, then consume its whole stream with stalls
  // on odd ops; returns the number of ops seen.
  task automatic run_one(input logic [31:0] ins, input bit stall, output int ops);
    int n = 0;
    int off;
    int k = 0;
    bit w = ins[21];
    ops = 0;
    for (int b = 0; b < 16; b++) n += int'(ins[b]);
    off = b_start(ins, n);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready idle", in_ready, 1);
    in_valid = 1'b1; in_instr = ins;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1 first op next cycle", out_valid, 1);
    // base copy
    chk(out_kind == 2'd0, "R3 kind", out_kind, 0);
    chk(out_reg == ins[19:16], "R3 reg", out_reg, ins[19:16]);
    chk(out_word == {ins[31:16], 16'h0}, "R3 word", out_word, {ins[31:16], 16'h0});
    chk(out_offset == 8'd0, "R3 offset", out_offset, 0);
    chk(out_last == (n == 0 && !w), "R10 last on base", out_last, (n == 0 && !w));
    for (int op = 0; op < 1 + n + int'(w); op++) begin
      logic [1:0] sk; logic [3:0] sr; logic [7:0] so; logic [31:0] sw; logic sl;
      if (stall && op % 2 == 1) begin
        out_ready = 1'b0;
        in_valid = 1'b1; in_instr = 32'hE8900001;
        sk = out_kind; sr = out_reg; so = out_offset; sw = out_word; sl = out_last;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 busy not ready", in_ready, 0);
        chk(out_kind == sk && out_reg == sr && out_offset == so &&
            out_word == sw && out_last == sl, "R11 stable while stalled",
            {out_kind, out_reg, out_offset}, {sk, sr, so});
        in_valid = 1'b0;
      end
      chk(out_valid == 1'b1, "R2 op present", out_valid, 1);
      if (op >= 1 && op <= n) begin
        while (k < 16 && !ins[k]) k++;
        chk(out_kind == 2'd1, "R4 transfer kind", out_kind, 1);
        chk(out_reg == 4'(k), "R4 ascending index", out_reg, k);
        chk(out_load == ins[20], "R4 load flag", out_load, ins[20]);
        chk($signed(out_offset) == 8'(off), (op == 1) ? "R5 start offset" : "R6 step",
            out_offset, 8'(off));
        chk(out_last == (op == n && !w), "R10 last on transfer", out_last, (op == n && !w));
        off = ins[23] ? off + 4 : off - 4;
        k++;
      end else if (op == n + 1) begin
        logic [31:0] ew;
        ew = {ins[31:28], 28'h0} | 32'h02400000 | {12'h0, ins[19:16], ins[19:16], 12'(4 * n)};
        chk(out_kind == (ins[23] ? 2'd2 : 2'd3), "R9 add/sub", out_kind, ins[23] ? 2 : 3);
        chk(out_word == ew, "R8 writeback word", out_word, ew);
        chk(out_reg == ins[19:16], "R8 writeback reg", out_reg, ins[19:16]);
        chk(out_last == 1'b1, "R10 last on writeback", out_last, 1);
      end
      out_ready = 1'b1;
      ops++;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(out_valid == 1'b0, "R2 stream ends", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ops;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && bad_mode == 1'b0, "R1 reset quiet", out_valid, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      run_one(VEC[v], v % 2 == 0, ops);
      chk(ops == VCNT[v], "R2 op count", ops, VCNT[v]);
    end
    // unsupported modes: 0x0A, 0x1F, 0x00
    for (int b = 0; b < 3; b++) begin
      logic [31:0] bi;
      bi = (b == 0) ? 32'hE8A10001 : (b == 1) ? 32'hE9F00001 : 32'hE8000001;
      @(negedge clk);
      in_valid = 1'b1; in_instr = bi;
      @(negedge clk);
      in_valid = 1'b0;
      chk(bad_mode == 1'b1, "R7 error pulse", bad_mode, 1);
      chk(out_valid == 1'b0, "R7 no micro-op", out_valid, 0);
      @(negedge clk);
      chk(bad_mode == 1'b0 && out_valid == 1'b0, "R7 single pulse", bad_mode, 0);
    end
    // good instruction right after a reject still works
    run_one(32'hE9150006, 1'b1, ops);
    chk(ops == 3, "R7 recovery count", ops, 3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule